// File: doc/BRIEF.md
# Sixteen-bit timer with shared capture/reload register

The block is an up-counter with one companion register that serves two jobs. A mode input picks the job. In reload mode the register holds the start value: each time the count rolls over from all ones, the counter is loaded from it. In capture mode the counter wraps to zero on its own. A falling edge on an external capture pin then copies the running count into the register, so software can time external events against the counter.

The count advances on a tick. A tick is one of three things: every system clock, every DIV-th system clock from a free-running prescaler, or a falling edge on an external count pin. A run input gates the tick. Both pins pass through synchronizer flops before the falling edge is detected. An overflow flag and an external-event flag are sticky and are cleared by software pulses. The interrupt request is the enabled OR of the two flags. Software writes the counter and the register through write strobes with data.

Top module: `cap_reload_timer`

## Requirements
- R1: While `run_i`=1 the count rises by one on each tick, and it holds while `run_i`=0. A tick is defined as follows. With `cnt_sel_i`=0 and `fast_clk_i`=1, every clock is a tick. With `cnt_sel_i`=0 and `fast_clk_i`=0, a tick comes once every DIV clocks, from a prescaler that runs freely from reset. With `cnt_sel_i`=1, a tick is a falling edge of `cnt_pin_i`, which takes effect on the second rising edge after the first edge that samples the pin low.
- R2: A tick at count FFFFh sets the overflow flag. The counter then becomes 0000h when `mode_cap_i`=1, or takes the register value when `mode_cap_i`=0.
- R3: With `mode_cap_i`=1 and `ext_en_i`=1, a falling edge of `cap_pin_i` copies the count into the register. The edge has the same synchronizer latency as in R1. If a tick falls in the same cycle, the value copied is the count before that increment.
- R4: With `ext_en_i`=1, every accepted falling edge of `cap_pin_i` sets the external flag in either mode. In reload mode the register is left unchanged.
- R5: With `ext_en_i`=0, edges on `cap_pin_i` are ignored: the register and the external flag do not change.
- R6: `irq_o` is high exactly when `irq_en_i`=1 and at least one flag is set. It follows without a clock delay.
- R7: Each flag stays set until its clear pulse (`clr_ovf_i`, `clr_ext_i`). A hardware set in the same cycle as a clear leaves the flag set.
- R8: `wr_cnt_i` and `wr_reg_i` load their data at the next clock. A write wins over a tick, a reload or a capture in the same cycle. A reload in that cycle uses the register value from before the write.
- R9: With the register at the two's complement of N, the counter at FFFFh, reload mode and one tick per clock, overflows occur on the first tick and then every N ticks.
- R10: After reset the count, the register and both flags are zero, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counting enable |
| cnt_sel_i | input | 1 | 1: ticks from count pin, 0: internal ticks |
| fast_clk_i | input | 1 | Internal tick every clock (1) or every DIV clocks (0) |
| mode_cap_i | input | 1 | 1: capture mode, 0: reload mode |
| ext_en_i | input | 1 | Accept falling edges on the capture pin |
| irq_en_i | input | 1 | Interrupt enable |
| cnt_pin_i | input | 1 | External count pin, asynchronous |
| cap_pin_i | input | 1 | External capture pin, asynchronous |
| wr_cnt_i | input | 1 | Write strobe for the counter |
| wr_cnt_data_i | input | WIDTH | Counter write data |
| wr_reg_i | input | 1 | Write strobe for the capture/reload register |
| wr_reg_data_i | input | WIDTH | Register write data |
| clr_ovf_i | input | 1 | Clear pulse for the overflow flag |
| clr_ext_i | input | 1 | Clear pulse for the external flag |
| count_o | output | WIDTH | Current count |
| reg_o | output | WIDTH | Capture/reload register |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ext_flag_o | output | 1 | Sticky external-event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench keeps WIDTH at 16 and the synchronizer at two stages. It lowers DIV to 3, so the divided tick is checked over many periods within a short run. The counter and register are preloaded near FFFFh, which brings wraps in both modes, the reload period, and overflow or capture in the same cycle as a clear or a write within a few cycles.

// File: rtl/tck_pkg.sv
package tck_pkg;
  typedef enum logic {
    MODE_RELOAD  = 1'b0,
    MODE_CAPTURE = 1'b1
  } tmr_mode_e;

  function automatic int unsigned cnt_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tck_sync_fall.sv
module tck_sync_fall #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  // previous synced level high, current low
  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/tck_prescale.sv
module tck_prescale #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pulse_o
);
  localparam int unsigned PW = tck_pkg::cnt_bits(DIV);

  generate
    if (DIV <= 1) begin : g_bypass
      assign pulse_o = 1'b1;
    end else begin : g_div
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
      end
      assign pulse_o = (pre_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/tck_sticky.sv
module tck_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer #(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned DIV         = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cnt_sel_i,
  input  logic             fast_clk_i,
  input  logic             mode_cap_i,
  input  logic             ext_en_i,
  input  logic             irq_en_i,
  input  logic             cnt_pin_i,
  input  logic             cap_pin_i,
  input  logic             wr_cnt_i,
  input  logic [WIDTH-1:0] wr_cnt_data_i,
  input  logic             wr_reg_i,
  input  logic [WIDTH-1:0] wr_reg_data_i,
  input  logic             clr_ovf_i,
  input  logic             clr_ext_i,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] reg_o,
  output logic             ovf_flag_o,
  output logic             ext_flag_o,
  output logic             irq_o
);
  import tck_pkg::*;

  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  tmr_mode_e       mode;
  logic            cnt_fall, cap_fall, pre_pulse;
  logic            tick, wrap, cap_evt;
  logic [WIDTH-1:0] count_q, reg_q;

  assign mode = tmr_mode_e'(mode_cap_i);

  tck_sync_fall #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(cnt_pin_i), .fall_o(cnt_fall));
  tck_sync_fall #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(cap_pin_i), .fall_o(cap_fall));
  tck_prescale #(.DIV(DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_o(pre_pulse));

  assign tick    = run_i & (cnt_sel_i ? cnt_fall : (fast_clk_i | pre_pulse));
  assign wrap    = tick & (count_q == CNT_MAX);
  assign cap_evt = ext_en_i & cap_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_q <= '0;
    else if (wr_cnt_i) count_q <= wr_cnt_data_i;
    else if (wrap)     count_q <= (mode == MODE_CAPTURE) ? '0 : reg_q;
    else if (tick)     count_q <= count_q + 1'b1;
  end

  // capture takes the pre-increment count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               reg_q <= '0;
    else if (wr_reg_i)                         reg_q <= wr_reg_data_i;
    else if (cap_evt && mode == MODE_CAPTURE)  reg_q <= count_q;
  end

  tck_sticky u_ovf (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(wrap), .clr_i(clr_ovf_i), .q_o(ovf_flag_o));
  tck_sticky u_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(cap_evt), .clr_i(clr_ext_i), .q_o(ext_flag_o));

  assign irq_o   = irq_en_i & (ovf_flag_o | ext_flag_o);
  assign count_o = count_q;
  assign reg_o   = reg_q;

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_cnt_i) |=> $stable(count_q));
  p_ovf_from_max_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_o) |-> ($past(count_q) == CNT_MAX));
  p_ext_needs_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_flag_o) |-> $past(ext_en_i));
  p_reg_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!ext_en_i || !mode_cap_i) && !wr_reg_i) |=> $stable(reg_q));
  p_reset_r10: assert property (@(posedge clk_i)
    !rst_ni |-> (count_q == '0 && !irq_o));
endmodule

// File: tb/cap_reload_timer_tb.sv
module cap_reload_timer_tb;
  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, cnt_sel = 0, fast = 0, mode_cap = 0, ext_en = 0, irq_en = 0;
  logic cnt_pin = 1, cap_pin = 1, wr_cnt = 0, wr_reg = 0, clr_ovf = 0, clr_ext = 0;
  logic [15:0] wr_cnt_data = 0, wr_reg_data = 0;
  logic [15:0] count, regv;
  logic ovf, ext, irq;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cap_reload_timer #(.WIDTH(16), .DIV(DIV), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cnt_sel_i(cnt_sel),
    .fast_clk_i(fast), .mode_cap_i(mode_cap), .ext_en_i(ext_en),
    .irq_en_i(irq_en), .cnt_pin_i(cnt_pin), .cap_pin_i(cap_pin),
    .wr_cnt_i(wr_cnt), .wr_cnt_data_i(wr_cnt_data), .wr_reg_i(wr_reg),
    .wr_reg_data_i(wr_reg_data), .clr_ovf_i(clr_ovf), .clr_ext_i(clr_ext),
    .count_o(count), .reg_o(regv), .ovf_flag_o(ovf), .ext_flag_o(ext), .irq_o(irq));

  // reference model
  logic [15:0] m_cnt, m_reg;
  logic m_ovf, m_ext;
  int m_pre;
  logic [2:0] ksh, csh;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_reg = 0; m_ovf = 0; m_ext = 0; m_pre = 0; ksh = 0; csh = 0;
    end else begin
      logic kf, cf, pp, tk, cap, ov;
      logic [15:0] nc, nr;
      kf = ksh[2] & ~ksh[1];
      cf = csh[2] & ~csh[1];
      pp = (m_pre == DIV - 1);
      tk = run & (cnt_sel ? kf : (fast | pp));
      cap = ext_en & cf;
      nc = m_cnt; nr = m_reg; ov = 0;
      if (tk) begin
        if (m_cnt == 16'hFFFF) begin ov = 1; nc = mode_cap ? 16'h0 : m_reg; end
        else nc = m_cnt + 16'h1;
      end
      if (mode_cap && cap) nr = m_cnt;
      if (wr_cnt) nc = wr_cnt_data;
      if (wr_reg) nr = wr_reg_data;
      m_ovf = ov | (m_ovf & ~clr_ovf);
      m_ext = cap | (m_ext & ~clr_ext);
      m_pre = pp ? 0 : m_pre + 1;
      ksh = {ksh[1:0], cnt_pin};
      csh = {csh[1:0], cap_pin};
      m_cnt = nc; m_reg = nr;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (count !== m_cnt) begin errors++; $display("FAIL R1 R2 count act=%h exp=%h", count, m_cnt); end
      if (regv !== m_reg) begin errors++; $display("FAIL R3 reg act=%h exp=%h", regv, m_reg); end
      if (ovf !== m_ovf) begin errors++; $display("FAIL R7 ovf act=%b exp=%b", ovf, m_ovf); end
      if (ext !== m_ext) begin errors++; $display("FAIL R4 ext act=%b exp=%b", ext, m_ext); end
      if (irq !== (irq_en & (m_ovf | m_ext))) begin
        errors++; $display("FAIL R6 irq act=%b exp=%b", irq, irq_en & (m_ovf | m_ext));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] c, input logic [15:0] r);
    wr_cnt = 1; wr_cnt_data = c; wr_reg = 1; wr_reg_data = r;
    cyc(1);
    wr_cnt = 0; wr_reg = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int hits, first, last;
    logic [15:0] snap;
    #1;
    chk("R10 count", count, 16'h0);
    chk("R10 flags", {14'h0, ovf, irq}, 16'h0);
    cyc(2);
    rst_n = 1;
    cyc(1);
    chk("R10 reg", regv, 16'h0);

    // R1 internal ticks
    run = 1; fast = 1; cyc(10);
    run = 0; snap = count; cyc(5);
    chk("R1 hold", count, snap);
    run = 1; fast = 0; cyc(30);
    run = 0;

    // R9 reload period, N=5
    load(16'hFFFF, 16'hFFFB);
    clr_ovf = 1; run = 1; fast = 1;
    hits = 0; first = -1; last = -1;
    for (int i = 0; i < 16; i++) begin
      cyc(1);
      if (ovf) begin
        if (first < 0) first = i;
        else chk("R9 spacing", 16'(i - last), 16'd5);
        last = i; hits++;
      end
    end
    chk("R9 first", 16'(first), 16'd0);
    chk("R9 count", 16'(hits), 16'd4);
    clr_ovf = 0; run = 0;

    // R2 capture-mode wrap
    mode_cap = 1;
    load(16'hFFFF, 16'h1234);
    run = 1; cyc(1);
    chk("R2 wrap", count, 16'h0000);
    chk("R2 ovf", {15'h0, ovf}, 16'h1);
    cyc(3);
    run = 0;

    // R7 set with clear in same cycle
    clr_ovf = 1; cyc(1); clr_ovf = 0;
    load(16'hFFFF, 16'h0);
    run = 1; clr_ovf = 1; cyc(1);
    clr_ovf = 0; run = 0;
    chk("R7 set wins", {15'h0, ovf}, 16'h1);
    cyc(4);
    chk("R7 sticky", {15'h0, ovf}, 16'h1);

    // R6 irq gating
    irq_en = 1; #1;
    chk("R6 irq on", {15'h0, irq}, 16'h1);
    irq_en = 0; #1;
    chk("R6 irq off", {15'h0, irq}, 16'h0);
    clr_ovf = 1; irq_en = 1; cyc(1); clr_ovf = 0;
    chk("R6 irq clear", {15'h0, irq}, 16'h0);

    // R3 capture while stopped
    load(16'h1234, 16'h0);
    ext_en = 1; cap_pin = 0; cyc(4);
    chk("R3 capture", regv, 16'h1234);
    chk("R3 ext", {15'h0, ext}, 16'h1);
    cap_pin = 1; cyc(3);
    // R3 capture while running
    run = 1; fast = 1; cap_pin = 0; cyc(3); cap_pin = 1; cyc(4);
    cap_pin = 0; cyc(2); cap_pin = 1; cyc(5);
    run = 0;

    // R4 reload mode: flag only
    clr_ext = 1; cyc(1); clr_ext = 0;
    mode_cap = 0;
    load(16'h0010, 16'h55AA);
    cap_pin = 0; cyc(4);
    chk("R4 reg kept", regv, 16'h55AA);
    chk("R4 ext", {15'h0, ext}, 16'h1);
    cap_pin = 1; cyc(3);

    // R5 disabled edges
    clr_ext = 1; cyc(1); clr_ext = 0;
    mode_cap = 1; ext_en = 0;
    cap_pin = 0; cyc(3); cap_pin = 1; cyc(3); cap_pin = 0; cyc(4);
    chk("R5 reg", regv, 16'h55AA);
    chk("R5 ext", {15'h0, ext}, 16'h0);
    cap_pin = 1; cyc(3);

    // R8 write priority
    run = 1; fast = 1;
    wr_cnt = 1; wr_cnt_data = 16'h0100; cyc(1); wr_cnt = 0;
    chk("R8 cnt write", count, 16'h0100);
    ext_en = 1; cap_pin = 0; cyc(2);
    wr_reg = 1; wr_reg_data = 16'hBEEF; cyc(1); wr_reg = 0;
    chk("R8 reg write", regv, 16'hBEEF);
    cap_pin = 1; cyc(3);
    mode_cap = 0;
    wr_cnt = 1; wr_cnt_data = 16'hFFFF; cyc(1);
    wr_cnt_data = 16'h4000; cyc(1); wr_cnt = 0;
    chk("R8 over reload", count, 16'h4000);
    run = 0;

    // R1 counter mode from pin
    cnt_sel = 1; run = 1;
    snap = count;
    for (int i = 0; i < 6; i++) begin
      cnt_pin = 0; cyc(1 + (i % 3)); cnt_pin = 1; cyc(2 + (i % 2));
    end
    cyc(3);
    chk("R1 pin ticks", count, snap + 16'd6);
    run = 0; cnt_sel = 0;
    cyc(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule